// File: doc/BRIEF.md
# Direct-Register Host FIFO Port with Mailboxes

This block sits between a host bus and an on-board controller. It moves byte streams in both directions through two FIFOs, and it passes short control messages through a pair of single-entry mailboxes. Every host register is reached by its own address, so no pointer register is needed. The host sees five locations:

| Offset | Read | Write |
|---|---|---|
| 0 | Inbound data | Outbound data |
| 1 | Zero | Ignored |
| 2 | Status | Interrupt mask and readback select |
| 3 | A mailbox | Outbound mailbox |
| 7 | Zero | Block reset |

The board side is a simple stub port. It drains the outbound FIFO one byte per cycle, fills the inbound FIFO, loads the inbound mailbox and consumes the outbound mailbox.

A configuration pin selects the host path width.

- **16-bit mode:** each data access moves two bytes. The whole storage of `DEPTH` bytes is usable.
- **8-bit mode:** each data access moves one byte. Only half the storage is usable.

The interrupt line is the OR of the status conditions that the mask enables. It is also gated by a global enable. The global enable is off after any reset and is set only by the board.

Top module: `fifo_host_port`

## Requirements
- R1: Offset 0 is a byte FIFO in both directions, and order is preserved. A host write at offset 0 appends to the outbound FIFO. A host read at offset 0 returns the oldest inbound byte and removes it. When the inbound FIFO is empty the read returns zero. Accesses to offset 1 and reads of offset 7 return zero and change nothing. `h_rdata` is zero whenever `h_rd` is low.
- R2: When `cfg_wide`=1, a word write appends `h_wdata[7:0]` first and `h_wdata[15:8]` second. A word read returns the oldest byte on `h_rdata[7:0]` and the next byte on `h_rdata[15:8]`, and removes both. If fewer than two bytes are present, the read removes only those present, and missing bytes read as zero. When `cfg_wide`=0, only `h_rdata[7:0]` carries data.
- R3: The usable capacity is `DEPTH` bytes in 16-bit mode and `DEPTH/2` bytes in 8-bit mode.
  - A host data write is dropped whole when the outbound free space is smaller than the access width.
  - A board push into a full inbound FIFO is dropped.
- R4: Status, read at offset 2, has these bits:
  - bit 7: outbound mailbox full
  - bit 6: outbound free space smaller than the access width
  - bit 5: inbound empty
  - bit 4: outbound count at least half the capacity
  - bit 3: inbound count at least half the capacity
  - bit 2: inbound mailbox full
  - bit 1: inbound count equals the capacity
  - bit 0: outbound empty

  After reset the status reads 0x21.
- R5: A write at offset 2 loads the mask. Bits 6, 5, 3, 2 and 0 enable interrupt sources. Bit 7 is the mailbox readback select. Bits 4 and 1 are always stored as zero.
- R6: Both mailboxes hold only bits 7..2 of the written value. Bits 1..0 always read as zero, both on `h_rdata` and on `brd_out_mbx`.
- R7: A host read at offset 3 works as follows.
  - With mask bit 7 clear, it returns the inbound mailbox and clears the inbound-mailbox-full flag.
  - With mask bit 7 set, it returns the outbound mailbox and clears nothing.
  - A board mailbox write in the same cycle as the clearing read leaves the flag set and holds the new value.
- R8: A host write at offset 3 loads the outbound mailbox and sets status bit 7. `brd_mbx_rd` clears that bit but keeps the stored value. If a host write and a board consume fall in the same cycle, the bit stays set.
- R9: `irq` is high when the global enable is set and any enabled pairing holds. The pairings of mask bit to status bit are:
  - mask 6 → status 2
  - mask 5 → status 1
  - mask 3 → status 5
  - mask 2 → status 6
  - mask 0 → status 0

  `brd_irq_arm` sets the global enable.
- R10: A host write at offset 7 has the following effects from the next cycle:
  - it empties both FIFOs and clears both mailboxes with their flags, the mask and the global enable;
  - it wins over every other action in that cycle;
  - it drives `board_rst` high for exactly that one following cycle.
- R11: The board side works as follows.
  - `brd_out_data` shows the oldest outbound byte, or zero when the outbound FIFO is empty.
  - `brd_pop` removes that byte, and does nothing when the FIFO is empty.
  - `brd_push` appends `brd_in_data` to the inbound FIFO.
  - `brd_mbx_wr` loads the inbound mailbox and sets its flag.
- R12: Host and board actions on the same FIFO in the same cycle both take effect. Full and empty decisions use the counts from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1 selects 16-bit host data path |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_addr | input | 3 | Host register offset |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request to the host |
| brd_pop | input | 1 | Board removes one outbound byte |
| brd_out_data | output | 8 | Oldest outbound byte |
| brd_push | input | 1 | Board appends one inbound byte |
| brd_in_data | input | 8 | Inbound byte from the board |
| brd_mbx_wr | input | 1 | Board loads the inbound mailbox |
| brd_mbx_data | input | 8 | Inbound mailbox value |
| brd_mbx_rd | input | 1 | Board consumes the outbound mailbox |
| brd_out_mbx | output | 8 | Outbound mailbox contents |
| brd_irq_arm | input | 1 | Board sets the interrupt global enable |
| board_rst | output | 1 | One-cycle pulse after a host reset write |

## Verification
Two functions that can fall in the same cycle are the host side and the board side of the same FIFO or mailbox. One example is a host word write while the board pops the outbound FIFO at its full boundary. Another is a board mailbox load in the cycle where the host read would clear the inbound flag. The directed phases drive these pairs together on purpose. A long random phase then makes any pairing likely. A behavioural queue model judges every cycle, and it decides full and empty from the counts before the cycle, as R12 states.

// File: rtl/hostport_pkg.sv
// Package: shared constants for the direct-register host FIFO port.
// Assumes: status and mask are 8 bits wide; the address is 3 bits wide.
package hostport_pkg;
    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_CTRL = 3'd2;
    localparam logic [2:0] OFS_MBX  = 3'd3;
    localparam logic [2:0] OFS_RST  = 3'd7;

    localparam logic [7:0] MASK_KEEP = 8'hED;
    localparam logic [7:0] MBX_KEEP  = 8'hFC;
    localparam int         SEL_BIT   = 7;
    localparam int         NPAIR     = 5;

    // mask bit index of interrupt pairing i
    function automatic int pair_mask(input int i);
        case (i)
            0: pair_mask = 6;
            1: pair_mask = 5;
            2: pair_mask = 3;
            3: pair_mask = 2;
            default: pair_mask = 0;
        endcase
    endfunction

    // status bit index of interrupt pairing i
    function automatic int pair_stat(input int i);
        case (i)
            0: pair_stat = 2;
            1: pair_stat = 1;
            2: pair_stat = 5;
            3: pair_stat = 6;
            default: pair_stat = 0;
        endcase
    endfunction
endpackage

// File: rtl/hp_byte_fifo.sv
// Byte FIFO that accepts up to two bytes in and two bytes out per cycle.
// Assumes: DEPTH is a power of two; the caller never over-pushes or over-pops
// (it limits push_n and pop_n using count).
module hp_byte_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic [1:0]                   push_n,
    input  logic [15:0]                  push_data,
    input  logic [1:0]                   pop_n,
    output logic [15:0]                  head,
    output logic [$clog2(DEPTH):0]       count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW-1:0] wp1, rp1;

    assign wp1  = wp + AW'(1);
    assign rp1  = rp + AW'(1);
    assign head = {mem[rp1], mem[rp]};

    // storage write, low byte first
    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wp] <= push_data[7:0];
        if (push_n == 2'd2) mem[wp1] <= push_data[15:8];
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + AW'(push_n);
            rp    <= rp + AW'(pop_n);
            count <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    // R3
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R1
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> CW'(pop_n) <= count);
endmodule

// File: rtl/hp_mailboxes.sv
// Pair of six-bit mailboxes with full flags.
// Assumes: values arrive already masked to bits 7..2.
// The outbound value is kept when the board consumes it; only the flag drops.
module hp_mailboxes (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       h_load_out,
    input  logic [7:0] h_val,
    input  logic       h_take_in,
    input  logic       b_load_in,
    input  logic [7:0] b_val,
    input  logic       b_take_out,
    output logic [7:0] out_val,
    output logic [7:0] in_val,
    output logic       out_full,
    output logic       in_full
);
    // outbound mailbox: host loads, board consumes
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            out_val  <= '0;
            out_full <= 1'b0;
        end else if (h_load_out) begin
            out_val  <= h_val;
            out_full <= 1'b1;
        end else if (b_take_out) begin
            out_full <= 1'b0;
        end
    end

    // inbound mailbox: board loads, host read clears
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            in_val  <= '0;
            in_full <= 1'b0;
        end else if (b_load_in) begin
            in_val  <= b_val;
            in_full <= 1'b1;
        end else if (h_take_in) begin
            in_full <= 1'b0;
        end
    end

    // R8
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_load_out && !clr |=> out_full);
    // R8
    ob_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_take_out && !h_load_out && !clr |=> !out_full && out_val == $past(out_val));
    // R7
    ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_take_in && !b_load_in && !clr |=> !in_full);
    // R6
    mbx_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_val[1:0] == 2'b00 && in_val[1:0] == 2'b00);
endmodule

// File: rtl/hp_irq_map.sv
// Interrupt combiner: each pairing routes one mask bit to one status bit,
// and the result is gated by the global enable.
// Assumes: the pairing table comes from hostport_pkg.
module hp_irq_map
    import hostport_pkg::*;
(
    input  logic       glob_en,
    input  logic [7:0] mask,
    input  logic [7:0] status,
    output logic       irq
);
    logic [NPAIR-1:0] hit;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        localparam int MB = pair_mask(g);
        localparam int SB = pair_stat(g);
        assign hit[g] = mask[MB] & status[SB];
    end

    assign irq = glob_en & (|hit);
endmodule

// File: rtl/fifo_host_port.sv
// Direct-register host port with two byte FIFOs and two six-bit mailboxes.
// Assumes: host strobes last one cycle; cfg_wide changes only while both
// FIFOs are empty; read data is combinational in the strobe cycle.
module fifo_host_port
    import hostport_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wide,
    input  logic        h_rd,
    input  logic        h_wr,
    input  logic [2:0]  h_addr,
    input  logic [15:0] h_wdata,
    output logic [15:0] h_rdata,
    output logic        irq,
    input  logic        brd_pop,
    output logic [7:0]  brd_out_data,
    input  logic        brd_push,
    input  logic [7:0]  brd_in_data,
    input  logic        brd_mbx_wr,
    input  logic [7:0]  brd_mbx_data,
    input  logic        brd_mbx_rd,
    output logic [7:0]  brd_out_mbx,
    input  logic        brd_irq_arm,
    output logic        board_rst
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0] cap, half, out_cnt, in_cnt, out_free;
    logic [1:0]    acc_w, o_push, o_pop, i_push, i_pop, in_avail;
    logic [15:0]   out_head, in_head;
    logic [7:0]    mask_q, status, ob_val, ib_val;
    logic          ob_full, ib_full, glob_en;
    logic          rd_any, wr_rst, wr_data, rd_data, wr_mbx, rd_mbx_in;

    assign cap      = cfg_wide ? CW'(DEPTH) : CW'(DEPTH / 2);
    assign half     = cap >> 1;
    assign acc_w    = cfg_wide ? 2'd2 : 2'd1;
    assign out_free = cap - out_cnt;

    assign rd_any    = h_rd && !h_wr;
    assign wr_rst    = h_wr && h_addr == OFS_RST;
    assign wr_data   = h_wr && h_addr == OFS_DATA;
    assign rd_data   = rd_any && h_addr == OFS_DATA;
    assign wr_mbx    = h_wr && h_addr == OFS_MBX;
    assign rd_mbx_in = rd_any && h_addr == OFS_MBX && !mask_q[SEL_BIT];

    // push/pop amounts from pre-cycle counts
    always_comb begin
        o_push   = (wr_data && out_free >= CW'(acc_w)) ? acc_w : 2'd0;
        o_pop    = (brd_pop && out_cnt != '0) ? 2'd1 : 2'd0;
        i_push   = (brd_push && in_cnt != cap) ? 2'd1 : 2'd0;
        in_avail = (in_cnt >= CW'(2)) ? 2'd2 : in_cnt[1:0];
        i_pop    = 2'd0;
        if (rd_data) i_pop = cfg_wide ? in_avail : {1'b0, in_cnt != '0};
    end

    hp_byte_fifo #(.DEPTH(DEPTH)) u_out (
        .clk(clk), .rst_n(rst_n), .clr(wr_rst),
        .push_n(o_push), .push_data(h_wdata), .pop_n(o_pop),
        .head(out_head), .count(out_cnt));

    hp_byte_fifo #(.DEPTH(DEPTH)) u_in (
        .clk(clk), .rst_n(rst_n), .clr(wr_rst),
        .push_n(i_push), .push_data({8'h00, brd_in_data}), .pop_n(i_pop),
        .head(in_head), .count(in_cnt));

    hp_mailboxes u_mbx (
        .clk(clk), .rst_n(rst_n), .clr(wr_rst),
        .h_load_out(wr_mbx), .h_val(h_wdata[7:0] & MBX_KEEP),
        .h_take_in(rd_mbx_in),
        .b_load_in(brd_mbx_wr), .b_val(brd_mbx_data & MBX_KEEP),
        .b_take_out(brd_mbx_rd),
        .out_val(ob_val), .in_val(ib_val),
        .out_full(ob_full), .in_full(ib_full));

    // mask register, global enable, board reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n || wr_rst) begin
            mask_q  <= '0;
            glob_en <= 1'b0;
        end else begin
            if (h_wr && h_addr == OFS_CTRL) mask_q <= h_wdata[7:0] & MASK_KEEP;
            if (brd_irq_arm) glob_en <= 1'b1;
        end
        board_rst <= rst_n && wr_rst;
    end

    assign status = {ob_full,
                     out_free < CW'(acc_w),
                     in_cnt == '0,
                     out_cnt >= half,
                     in_cnt >= half,
                     ib_full,
                     in_cnt == cap,
                     out_cnt == '0};

    // host read mux
    always_comb begin
        h_rdata = '0;
        if (rd_any) begin
            case (h_addr)
                OFS_DATA: begin
                    if (in_cnt != '0) h_rdata[7:0] = in_head[7:0];
                    if (cfg_wide && in_cnt >= CW'(2)) h_rdata[15:8] = in_head[15:8];
                end
                OFS_CTRL: h_rdata[7:0] = status;
                OFS_MBX:  h_rdata[7:0] = mask_q[SEL_BIT] ? ob_val : ib_val;
                default:  h_rdata = '0;
            endcase
        end
    end

    hp_irq_map u_irq (.glob_en(glob_en), .mask(mask_q), .status(status), .irq(irq));

    assign brd_out_data = (out_cnt != '0) ? out_head[7:0] : 8'h00;
    assign brd_out_mbx  = ob_val;

    // R10
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst |=> status == 8'h21 && !irq && board_rst);
    // R10
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        board_rst |=> !board_rst || $past(wr_rst));
    // R3
    out_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= cap && in_cnt <= cap);
    // R11
    in_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brd_push && in_cnt == cap && !rd_data && !wr_rst |=> in_cnt == $past(in_cnt));
    // R6
    mbx_read_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any && h_addr == OFS_MBX |-> h_rdata[1:0] == 2'b00);
endmodule

// File: tb/tb_fifo_host_port.sv
module tb_fifo_host_port;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        h_rd = 0, h_wr = 0;
    logic [2:0]  h_addr = 0;
    logic [15:0] h_wdata = 0;
    logic [15:0] h_rdata;
    logic        irq;
    logic        brd_pop = 0, brd_push = 0, brd_mbx_wr = 0, brd_mbx_rd = 0, brd_irq_arm = 0;
    logic [7:0]  brd_in_data = 0, brd_mbx_data = 0;
    logic [7:0]  brd_out_data, brd_out_mbx;
    logic        board_rst;

    int checks = 0, failures = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0] oq[$];
    logic [7:0] iq[$];
    int m_mask = 0, m_ob = 0, m_ib = 0, m_obf = 0, m_ibf = 0, m_gen = 0, m_brst = 0;

    always #2 clk = ~clk;

    fifo_host_port #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
        .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .irq(irq), .brd_pop(brd_pop), .brd_out_data(brd_out_data),
        .brd_push(brd_push), .brd_in_data(brd_in_data),
        .brd_mbx_wr(brd_mbx_wr), .brd_mbx_data(brd_mbx_data), .brd_mbx_rd(brd_mbx_rd),
        .brd_out_mbx(brd_out_mbx), .brd_irq_arm(brd_irq_arm), .board_rst(board_rst));

    function automatic int cap_of();
        return cfg_wide ? DEPTH : DEPTH / 2;
    endfunction

    function automatic int acc_of();
        return cfg_wide ? 2 : 1;
    endfunction

    function automatic logic [7:0] m_status();
        int c = cap_of();
        logic [7:0] s = 8'h00;
        if (m_obf != 0) s |= 8'h80;
        if (c - oq.size() < acc_of()) s |= 8'h40;
        if (iq.size() == 0) s |= 8'h20;
        if (oq.size() >= c / 2) s |= 8'h10;
        if (iq.size() >= c / 2) s |= 8'h08;
        if (m_ibf != 0) s |= 8'h04;
        if (iq.size() == c) s |= 8'h02;
        if (oq.size() == 0) s |= 8'h01;
        return s;
    endfunction

    function automatic logic m_irq();
        logic [7:0] s = m_status();
        logic hit;
        hit = (m_mask[6] && s[2]) || (m_mask[5] && s[1]) || (m_mask[3] && s[5]) ||
              (m_mask[2] && s[6]) || (m_mask[0] && s[0]);
        return (m_gen != 0) && hit;
    endfunction

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: drive, compare outputs with the model, advance the model
    task automatic step(input string tag, input logic rd, input logic wr, input logic [2:0] a,
                        input logic [15:0] d, input logic bp, input logic bq, input logic [7:0] bd,
                        input logic bmw, input logic [7:0] bmd, input logic bmr, input logic arm);
        logic [15:0] er;
        int osz, isz, take;
        h_rd = rd; h_wr = wr; h_addr = a; h_wdata = d;
        brd_pop = bp; brd_push = bq; brd_in_data = bd;
        brd_mbx_wr = bmw; brd_mbx_data = bmd; brd_mbx_rd = bmr; brd_irq_arm = arm;
        #1;
        er = 16'h0;
        if (rd && !wr) begin
            case (a)
                3'd0: begin
                    if (iq.size() >= 1) er[7:0] = iq[0];
                    if (cfg_wide && iq.size() >= 2) er[15:8] = iq[1];
                end
                3'd2: er[7:0] = m_status();
                3'd3: er[7:0] = m_mask[7] ? 8'(m_ob) : 8'(m_ib);
                default: er = 16'h0;
            endcase
        end
        chk(tag, "h_rdata", h_rdata, er);
        chk(tag, "irq", {15'h0, irq}, {15'h0, m_irq()});
        chk(tag, "brd_out_data", {8'h0, brd_out_data}, {8'h0, (oq.size() > 0) ? oq[0] : 8'h00});
        chk(tag, "brd_out_mbx", {8'h0, brd_out_mbx}, 16'(m_ob));
        chk(tag, "board_rst", {15'h0, board_rst}, 16'(m_brst));
        osz = oq.size(); isz = iq.size();
        m_brst = 0;
        if (wr && a == 3'd7) begin
            oq.delete(); iq.delete();
            m_mask = 0; m_ob = 0; m_ib = 0; m_obf = 0; m_ibf = 0; m_gen = 0; m_brst = 1;
        end else begin
            if (rd && !wr && a == 3'd0) begin
                take = cfg_wide ? ((isz >= 2) ? 2 : isz) : ((isz >= 1) ? 1 : 0);
                for (int k = 0; k < take; k++) void'(iq.pop_front());
            end
            if (bp && osz > 0) void'(oq.pop_front());
            if (wr && a == 3'd0 && cap_of() - osz >= acc_of()) begin
                oq.push_back(d[7:0]);
                if (cfg_wide) oq.push_back(d[15:8]);
            end
            if (bq && isz < cap_of()) iq.push_back(bd);
            if (wr && a == 3'd2) m_mask = int'(d[7:0] & 8'hED);
            if (rd && !wr && a == 3'd3 && !m_mask[7]) m_ibf = 0;
            if (bmw) begin m_ib = int'(bmd & 8'hFC); m_ibf = 1; end
            if (bmr) m_obf = 0;
            if (wr && a == 3'd3) begin m_ob = int'(d[7:0] & 8'hFC); m_obf = 1; end
            if (arm) m_gen = 1;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hw(input string t, input logic [2:0] a, input logic [15:0] d);
        step(t, 0, 1, a, d, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic hr(input string t, input logic [2:0] a);
        step(t, 1, 0, a, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic bpop(input string t);
        step(t, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic bpush(input string t, input logic [7:0] d);
        step(t, 0, 0, 0, 0, 0, 1, d, 0, 0, 0, 0);
    endtask
    task automatic idle(input string t);
        step(t, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4 reset state
        hr("R4", 3'd2);
        idle("R4");
        // R1 narrow order and ignored offsets
        hw("R1", 3'd0, 16'hAA11);
        hw("R1", 3'd0, 16'h0022);
        hw("R1", 3'd1, 16'h5566);
        hr("R1", 3'd1);
        hr("R1", 3'd7);
        bpop("R11");
        bpop("R11");
        bpop("R11");
        // R3 narrow fill with one extra write dropped
        for (int k = 0; k < DEPTH / 2 + 1; k++) hw("R3", 3'd0, 16'(8'h30 + k));
        hr("R4", 3'd2);
        // R12 host write and board pop at the full boundary
        step("R12", 0, 1, 3'd0, 16'h00EE, 1, 0, 0, 0, 0, 0, 0);
        hr("R3", 3'd2);
        for (int k = 0; k < DEPTH / 2 + 1; k++) bpop("R11");
        // R11 inbound fill, extra push dropped
        for (int k = 0; k < DEPTH / 2 + 1; k++) bpush("R11", 8'(8'h60 + k));
        hr("R3", 3'd2);
        // R9 interrupt gating
        hw("R5", 3'd2, 16'h00FF);
        idle("R9");
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        idle("R9");
        // R12 host read and board push together
        step("R12", 1, 0, 3'd0, 0, 0, 1, 8'h7F, 0, 0, 0, 0);
        for (int k = 0; k < DEPTH / 2 + 1; k++) hr("R1", 3'd0);
        hw("R9", 3'd2, 16'h0008);
        idle("R9");
        // R6 R8 outbound mailbox
        hw("R6", 3'd3, 16'h00FF);
        hr("R8", 3'd2);
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        hr("R8", 3'd2);
        hw("R7", 3'd2, 16'h0080);
        hr("R7", 3'd3);
        step("R8", 0, 1, 3'd3, 16'h0044, 0, 0, 0, 0, 0, 1, 0);
        hr("R8", 3'd2);
        // R7 inbound mailbox
        hw("R7", 3'd2, 16'h0040);
        step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 8'hAB, 0, 0);
        hr("R7", 3'd2);
        step("R7", 1, 0, 3'd3, 0, 0, 0, 0, 1, 8'h57, 0, 0);
        hr("R7", 3'd2);
        hr("R7", 3'd3);
        hr("R7", 3'd2);
        // R10 reset write
        hw("R10", 3'd0, 16'h0001);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 8'hF0, 0, 1);
        hw("R10", 3'd7, 16'h0000);
        hr("R10", 3'd2);
        idle("R10");
        // R2 wide mode
        cfg_wide = 1'b1;
        idle("R2");
        hw("R2", 3'd0, 16'h3412);
        bpop("R2");
        bpop("R2");
        for (int k = 0; k < DEPTH / 2 + 1; k++) hw("R3", 3'd0, 16'(16'h0101 * (k + 1)));
        hr("R3", 3'd2);
        bpop("R12");
        hr("R3", 3'd2);
        hw("R3", 3'd0, 16'hBEEF);
        bpush("R2", 8'hC1);
        bpush("R2", 8'hC2);
        bpush("R2", 8'hC3);
        hr("R2", 3'd0);
        hr("R2", 3'd0);
        hr("R2", 3'd0);
        // R12 random mixing of both sides
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] a;
            logic rd, wr;
            int r = $urandom % 8;
            a = (r < 4) ? 3'd0 : (r < 6) ? 3'd3 : (r == 6) ? 3'd2 : (($urandom % 40 == 0) ? 3'd7 : 3'd0);
            rd = ($urandom % 2) == 1;
            wr = !rd && ($urandom % 3 != 0);
            step("R12", rd, wr, a, 16'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0,
                 8'($urandom), ($urandom % 9) == 0, 8'($urandom), ($urandom % 7) == 0,
                 ($urandom % 20) == 0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule